// File: doc/BRIEF.md
# Multi-Bank Aligned Clock Divider

This core divides one fast input clock into four independent output frequencies. The outputs are organised as four banks of two outputs each. Each bank takes its own 3-bit ratio code and produces a divided clock at 1, 2, 3, 4, 5, 6 or 8 times the input period. Both outputs of a bank carry the same divided waveform, and each output has its own enable.

The divided clocks are built from flops on both input clock edges. A divided high phase can therefore last any whole number of half input cycles, so odd ratios keep an exact 50% duty cycle. An active-low asynchronous reset holds every divider. On the first rising input edge after the reset is released, every enabled output goes high together. From then on, each output rises only on rising input edges, which keeps every bank aligned with a divide-by-1 output.

A ratio change and an enable change are both adopted only where the bank's period restarts, so no shortened pulse ever reaches an output.

Top module: `mbcd_top`

## Requirements
- R1: Bank b (0..3) reads its code from div_code_i[3b+2:3b] and produces a waveform with a period of N input cycles. The codes 000, 001, 010, 011, 100, 101 and 110 select N = 1, 2, 3, 4, 5, 6 and 8, and code 111 also selects N = 8.
- R2: In every period, the output is high for the first N half input cycles and low for the last N half input cycles, giving an exact 50% duty cycle for every ratio. At N = 1 the output is high during each high half of the input clock.
- R3: While rst_ni is low, all eight outputs are low and every divider is held.
- R4: On the first rising clk_i edge after rst_ni goes high, every output whose enable is high goes high on that same edge.
- R5: Every rising edge of every output coincides with a rising edge of clk_i. No output rises on a falling clk_i edge.
- R6: A new ratio code is adopted only at the rising edge that starts a new period of that bank. The period in progress completes with the old ratio.
- R7: Output k is clk_o[k] and belongs to bank k/2. Its enable, out_en_i[k], is sampled only at the edges where its bank starts a period. A disabled output is held low, and a re-enabled output resumes at the start of a period.
- R8: The two outputs of a bank that are both enabled carry identical waveforms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low asynchronous divider reset |
| div_code_i | input | 12 | Ratio codes, 3 bits per bank, bank 0 in the low bits |
| out_en_i | input | 8 | Per-output enables, bit k for output k |
| clk_o | output | 8 | Divided clocks, outputs 2b and 2b+1 belong to bank b |

## Verification
A bank's ratio update and the re-capture of its enables fall on the same rising edge, the one where its period restarts. The bench provokes this by changing codes and enables together in the middle of running periods, so each bank adopts both on one shared edge. A second coincidence is reset release with all four counters starting at once. It is provoked by re-asserting the reset in the middle of a run and then releasing it. A reference model predicts the output level for every half input cycle, and a scoreboard compares each sample against it. Windows of 120 cycles then count rising edges, high half cycles, rises on falling edges and mismatches between the two outputs of a bank.

// File: rtl/mbcd_pkg.sv
package mbcd_pkg;
  localparam int CODE_W  = 3;
  localparam int RATIO_W = 4;
  localparam int CNT_W   = 3;

  function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    code_to_ratio = 4'd1;
      3'd1:    code_to_ratio = 4'd2;
      3'd2:    code_to_ratio = 4'd3;
      3'd3:    code_to_ratio = 4'd4;
      3'd4:    code_to_ratio = 4'd5;
      3'd5:    code_to_ratio = 4'd6;
      default: code_to_ratio = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/mbcd_start.sv
module mbcd_start (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);
  logic run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign run_o = run_q;
endmodule

// File: rtl/mbcd_bank_ctr.sv
module mbcd_bank_ctr
  import mbcd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic               wrap_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               hi_p_o,
  output logic               hi_n_o
);
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic               wrap;

  // period restarts on the start edge or after the last cycle
  assign wrap    = !run_i || ({1'b0, cnt_q} == ratio_q - RATIO_W'(1));
  assign cnt_d   = wrap ? '0 : cnt_q + CNT_W'(1);
  assign ratio_d = wrap ? code_to_ratio(code_i) : ratio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= RATIO_W'(1);
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end

  // half-cycle index within period: 2*cnt (high half), 2*cnt+1 (low half)
  assign hi_p_o  = {1'b0, cnt_d, 1'b0} < {1'b0, ratio_d};
  assign hi_n_o  = {1'b0, cnt_q, 1'b1} < {1'b0, ratio_q};
  assign wrap_o  = wrap;
  assign ratio_o = ratio_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/mbcd_ddr_wave.sv
module mbcd_ddr_wave (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hi_p_i,
  input  logic hi_n_i,
  output logic wave_o
);
  logic p_q, n_q;

  // output is p_q ^ n_q; each edge sets the level for the following half cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_q <= 1'b0;
    else         p_q <= n_q ^ hi_p_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    n_q <= 1'b0;
    else if (run_i) n_q <= p_q ^ hi_n_i;
  end

  assign wave_o = p_q ^ n_q;
endmodule

// File: rtl/mbcd_top.sv
module mbcd_top
  import mbcd_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int OUTS_PER_BANK = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_BANKS*CODE_W-1:0]   div_code_i,
  input  logic [NUM_BANKS*OUTS_PER_BANK-1:0] out_en_i,
  output logic [NUM_BANKS*OUTS_PER_BANK-1:0] clk_o
);
  localparam int NUM_OUTS = NUM_BANKS * OUTS_PER_BANK;

  logic                         run_q;
  logic [NUM_BANKS-1:0]         wrap;
  logic [NUM_BANKS-1:0]         wave;
  logic [NUM_BANKS*RATIO_W-1:0] ratio_flat;
  logic [NUM_BANKS*CNT_W-1:0]   cnt_flat;
  logic [NUM_OUTS-1:0]          en_q;

  mbcd_start u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_o  (run_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hi_p, hi_n;

    mbcd_bank_ctr u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run_q),
      .code_i  (div_code_i[b*CODE_W +: CODE_W]),
      .wrap_o  (wrap[b]),
      .ratio_o (ratio_flat[b*RATIO_W +: RATIO_W]),
      .cnt_o   (cnt_flat[b*CNT_W +: CNT_W]),
      .hi_p_o  (hi_p),
      .hi_n_o  (hi_n)
    );

    mbcd_ddr_wave u_wave (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_q),
      .hi_p_i (hi_p),
      .hi_n_i (hi_n),
      .wave_o (wave[b])
    );

    for (genvar j = 0; j < OUTS_PER_BANK; j++) begin : g_out
      localparam int K = b * OUTS_PER_BANK + j;

      // enable taken only where the bank period restarts
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      en_q[K] <= 1'b0;
        else if (wrap[b]) en_q[K] <= out_en_i[K];
      end

      assign clk_o[K] = en_q[K] & wave[b];
    end
  end
endmodule

// File: rtl/mbcd_chk.sv
module mbcd_chk
  import mbcd_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int OUTS_PER_BANK = 2
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               run_i,
  input logic [NUM_BANKS-1:0]               wrap_i,
  input logic [NUM_BANKS*RATIO_W-1:0]       ratio_i,
  input logic [NUM_BANKS*CNT_W-1:0]         cnt_i,
  input logic [NUM_BANKS*OUTS_PER_BANK-1:0] en_q_i,
  input logic [NUM_BANKS*OUTS_PER_BANK-1:0] clk_o_i
);
  localparam int NUM_OUTS = NUM_BANKS * OUTS_PER_BANK;

  logic [NUM_OUTS-1:0] hi_half_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_half_q <= '0;
    else         hi_half_q <= clk_o_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) AST_RST_LOW: assert (clk_o_i == '0); // R3
  end

  AST_START_TOGETHER: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> clk_o_i == en_q_i); // R4

  AST_NO_FALL_EDGE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_o_i & ~hi_half_q) == '0); // R5

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      {1'b0, cnt_i[b*CNT_W +: CNT_W]} < ratio_i[b*RATIO_W +: RATIO_W]); // R1

    AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap_i[b] |=> $stable(ratio_i[b*RATIO_W +: RATIO_W])); // R6

    AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap_i[b] |=> $stable(en_q_i[b*OUTS_PER_BANK +: OUTS_PER_BANK])); // R7
  end
endmodule

bind mbcd_top mbcd_chk #(
  .NUM_BANKS     (NUM_BANKS),
  .OUTS_PER_BANK (OUTS_PER_BANK)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_q),
  .wrap_i  (wrap),
  .ratio_i (ratio_flat),
  .cnt_i   (cnt_flat),
  .en_q_i  (en_q),
  .clk_o_i (clk_o)
);

// File: tb/tb_mbcd_top.sv
`timescale 1ns/1ps
module tb_mbcd_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] code_drv;
  logic [7:0]  en_drv;
  logic [7:0]  clk_o;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;
  string cur_req = "R3";

  logic [7:0] exp_q[$];

  int rise_cnt [8];
  int high_cnt [8];
  int neg_rise = 0;
  int pair_mis = 0;
  logic [7:0] prev_s = '0;

  always #10 clk = ~clk;

  mbcd_top dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .div_code_i (code_drv),
    .out_en_i   (en_drv),
    .clk_o      (clk_o)
  );

  function automatic int ratio_of(input logic [2:0] c);
    case (c)
      3'd0: return 1;  3'd1: return 2;  3'd2: return 3;  3'd3: return 4;
      3'd4: return 5;  3'd5: return 6;  default: return 8;
    endcase
  endfunction

  // reference model: predicts the output level for each half cycle
  bit         m_run = 0;
  int         m_cnt [4];
  int         m_rat [4];
  logic [7:0] m_en = '0;

  always @(posedge clk) begin
    logic [7:0] eh, el;
    eh = '0; el = '0;
    if (!rst_n) begin
      m_run = 0;
      m_en  = '0;
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (!m_run || m_cnt[b] == m_rat[b] - 1) begin
          m_cnt[b] = 0;
          m_rat[b] = ratio_of(code_drv[b*3 +: 3]);
          m_en[2*b]   = en_drv[2*b];
          m_en[2*b+1] = en_drv[2*b+1];
        end else begin
          m_cnt[b] = m_cnt[b] + 1;
        end
      end
      m_run = 1;
      for (int k = 0; k < 8; k++) begin
        eh[k] = m_en[k] && (2*m_cnt[k/2]     < m_rat[k/2]);
        el[k] = m_en[k] && (2*m_cnt[k/2] + 1 < m_rat[k/2]);
      end
    end
    exp_q.push_back(eh);
    exp_q.push_back(el);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample(input bit low_half);
    logic [7:0] s, e;
    s = clk_o;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if (s !== e) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h t=%0t", cur_req, s, e, $time);
      end
    end
    for (int k = 0; k < 8; k++) begin
      if (s[k] && !prev_s[k]) begin
        rise_cnt[k]++;
        if (low_half) neg_rise++;
      end
      if (s[k]) high_cnt[k]++;
    end
    for (int b = 0; b < 4; b++) if (s[2*b] !== s[2*b+1]) pair_mis++;
    prev_s = s;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #5; sample(1'b0);
      @(negedge clk); #5; sample(1'b1);
    end
  end

  // 120-cycle window: a whole number of periods for every ratio
  task automatic window(input bit pairs_on);
    int r0 [8];
    int h0 [8];
    int nr0, pm0, n;
    @(posedge clk); #2;
    for (int k = 0; k < 8; k++) begin r0[k] = rise_cnt[k]; h0[k] = high_cnt[k]; end
    nr0 = neg_rise; pm0 = pair_mis;
    repeat (120) @(posedge clk);
    #2;
    for (int k = 0; k < 8; k++) begin
      n = ratio_of(code_drv[(k/2)*3 +: 3]);
      if (en_drv[k]) begin
        chk(rise_cnt[k] - r0[k] == 120 / n, "R1", rise_cnt[k] - r0[k], 120 / n);
        chk(high_cnt[k] - h0[k] == 120, "R2", high_cnt[k] - h0[k], 120);
      end else begin
        chk(rise_cnt[k] - r0[k] == 0, "R7", rise_cnt[k] - r0[k], 0);
        chk(high_cnt[k] - h0[k] == 0, "R7", high_cnt[k] - h0[k], 0);
      end
    end
    chk(neg_rise - nr0 == 0, "R5", neg_rise - nr0, 0);
    if (pairs_on) chk(pair_mis - pm0 == 0, "R8", pair_mis - pm0, 0);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
    end
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    code_drv = {3'b011, 3'b100, 3'b010, 3'b000}; // D=4 C=5 B=3 A=1
    en_drv   = 8'hFF;
    cur_req  = "R3";
    repeat (4) @(posedge clk);
    #7;
    chk(clk_o == 8'h00, "R3", int'(clk_o), 0);

    // release: all outputs rise on the next rising edge
    rst_n   = 1'b1;
    cur_req = "R4";
    @(posedge clk); #5;
    chk(clk_o == 8'hFF, "R4", int'(clk_o), 8'hFF);

    cur_req = "R2";
    repeat (20) @(posedge clk);
    window(1'b1);

    // ratio change mid-period, with code 111
    @(posedge clk); #7;
    code_drv = {3'b111, 3'b001, 3'b110, 3'b101}; // D=8 C=2 B=8 A=6
    cur_req  = "R6";
    repeat (20) @(posedge clk);
    cur_req  = "R1";
    window(1'b1);

    // enable and ratio change in the same period
    @(posedge clk); #7;
    en_drv   = 8'b0101_1010;
    code_drv = {3'b100, 3'b010, 3'b011, 3'b000}; // D=5 C=3 B=4 A=1
    cur_req  = "R7";
    repeat (20) @(posedge clk);
    window(1'b0);

    // re-enable: resume aligned with period start
    @(posedge clk); #7;
    en_drv  = 8'hFF;
    cur_req = "R7";
    repeat (20) @(posedge clk);
    window(1'b1);

    // reset in the middle of a run, then release again
    @(negedge clk); #7;
    rst_n   = 1'b0;
    cur_req = "R3";
    #1;
    chk(clk_o == 8'h00, "R3", int'(clk_o), 0);
    repeat (3) @(posedge clk);
    #7;
    en_drv = 8'b1111_0011;
    rst_n  = 1'b1;
    cur_req = "R4";
    @(posedge clk); #5;
    chk(clk_o == 8'hF3, "R4", int'(clk_o), 8'hF3);
    repeat (40) @(posedge clk);

    #3;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
    end
    $finish;
  end
endmodule